// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block watches the sampled level of a differential bus while the node is parked in a low-power mode. It looks for a wake-up signature made of three phases: a dominant stretch, a recessive stretch, and a second dominant stretch. Each phase must reach its own minimum length, counted in clock cycles. The whole signature must fit inside one timeout window. Brief excursions to the opposite level inside a phase do not restart it. They only stop that phase's count until the bus returns to the phase's level.

On success the block emits a single-cycle wake pulse and drops its receive-data indication. That indication is held high for as long as no wake-up has been recognised. An attempt is abandoned, with no wake reported, in any of these cases:

- the node goes to Normal mode;
- supply undervoltage is flagged;
- the window runs out.

After a wake-up the detector stays idle until the mode leaves the low-power states and comes back. The three timing limits are run-time inputs, so firmware or strap logic can set them from the bus bit rate.

Top module: `bus_wake_detector`

## Requirements
- R1: While reset is asserted and after it is released, `wake_o` is 0 and `rxd_o` is 1.
- R2: Detection needs three phases in order. First, `min_dom_i` samples with `bus_dom_i`=1. Second, `min_rec_i` samples with `bus_dom_i`=0. Third, `min_dom_i` samples with `bus_dom_i`=1. `wake_o` goes high for exactly one cycle, just after the clock edge that takes the final sample of the third phase.
- R3: While a phase is still counting, samples of the opposite level pause its count and do not clear it. Counting resumes when the bus returns to the phase's level.
- R4: The first dominant sample of an attempt is window cycle 1, and every later clock cycle adds one. The attempt is dropped if the pattern has not completed by window cycle `timeout_i`. The sample that falls beyond the window starts nothing. A following complete pattern is detected afresh.
- R5: `rxd_o` stays 1 until the wake event. It goes to 0 together with `wake_o` and stays 0 while `mode_i` remains in Standby or Sleep. It returns to 1 on the edge that samples a mode outside those two.
- R6: Sampling Normal mode (`mode_i`=2'b00) while a pattern is in progress drops the attempt, and no wake is reported for it.
- R7: Sampling `uv_i`=1 while a pattern is in progress drops the attempt, and no attempt starts while `uv_i`=1.
- R8: Detection runs only when `mode_i` is Standby (2'b10) or Sleep (2'b11). In Listen-only (2'b01) and Normal, bus activity produces no wake.
- R9: After a wake event no further wake is produced, whatever the bus does, until the detector is re-armed by a mode outside Standby/Sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| mode_i | input | 2 | Operating mode: 00 Normal, 01 Listen-only, 10 Standby, 11 Sleep |
| uv_i | input | 1 | Supply undervoltage flag |
| min_dom_i | input | CNT_W | Minimum dominant phase length in cycles |
| min_rec_i | input | CNT_W | Minimum recessive phase length in cycles |
| timeout_i | input | WIN_W | Pattern window length in cycles |
| wake_o | output | 1 | One-cycle wake event pulse |
| rxd_o | output | 1 | Receive indication, high until a wake event |

## Verification
The assertions check the following on every cycle:

- the wake pulse lasts a single cycle and coincides with `rxd_o` low;
- it follows a dominant sample taken in a low-power mode without undervoltage;
- it never repeats while `rxd_o` is low;
- `rxd_o` stays low or re-arms according to the sampled mode.

Only the bench's scenarios can show the rest:

- that pauses rather than restarts are applied inside phases;
- the exact cycle on which the window expires, and that the pattern is detected again afterwards;
- that aborted attempts never turn into a wake later.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_LISTEN  = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_SLEEP   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_ARMED = 3'd0,
    ST_DOM1  = 3'd1,
    ST_REC   = 3'd2,
    ST_DOM2  = 3'd3,
    ST_DONE  = 3'd4
  } state_e;

  function automatic logic is_low_power(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/bwd_phase_cnt.sv
module bwd_phase_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             hit_o
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + ONE;
  // qualifies on the sample that brings the count up to the minimum
  assign hit_o   = inc_i && (cnt_inc >= {1'b0, min_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !(&cnt_q)) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/bwd_win_timer.sv
module bwd_win_timer #(
  parameter int unsigned WIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [WIN_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  logic [WIN_W-1:0] cnt_q;

  // cnt_q holds window cycles already used; the next one is past the limit
  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= ONE;
    end else if (run_i && !(&cnt_q)) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       uv_i,
  input  logic       bus_dom_i,
  input  logic       hit_i,
  input  logic       expired_i,
  output logic       sel_rec_o,
  output logic       cnt_inc_o,
  output logic       cnt_clr_o,
  output logic       win_start_o,
  output logic       win_run_o,
  output logic       win_clr_o,
  output logic       wake_o,
  output logic       rxd_o
);
  state_e state_q, state_d;
  logic   wake_q, wake_d;
  logic   armed_ok, in_pat, live, start, want_dom, active;

  always_comb begin
    armed_ok = is_low_power(mode_i) && !uv_i;
    in_pat   = (state_q == ST_DOM1) || (state_q == ST_REC) || (state_q == ST_DOM2);
    live     = in_pat && armed_ok && !expired_i;
    start    = (state_q == ST_ARMED) && armed_ok && bus_dom_i;
    active   = start || live;
    want_dom = (state_q != ST_REC);
  end

  assign sel_rec_o   = (state_q == ST_REC);
  assign cnt_inc_o   = active && (bus_dom_i == want_dom);
  assign cnt_clr_o   = hit_i || !active;
  assign win_start_o = start;
  assign win_run_o   = live;
  assign win_clr_o   = !active;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_ARMED: if (start) state_d = hit_i ? ST_REC : ST_DOM1;
      ST_DOM1:  if (!live) state_d = ST_ARMED;
                else if (hit_i) state_d = ST_REC;
      ST_REC:   if (!live) state_d = ST_ARMED;
                else if (hit_i) state_d = ST_DOM2;
      ST_DOM2: begin
        if (!live) begin
          state_d = ST_ARMED;
        end else if (hit_i) begin
          state_d = ST_DONE;
          wake_d  = 1'b1;
        end
      end
      ST_DONE:  if (!is_low_power(mode_i)) state_d = ST_ARMED;
      default:  state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign wake_o = wake_q;
  assign rxd_o  = (state_q != ST_DONE);
endmodule

// File: rtl/bus_wake_detector.sv
module bus_wake_detector #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_dom_i,
  input  logic [1:0]       mode_i,
  input  logic             uv_i,
  input  logic [CNT_W-1:0] min_dom_i,
  input  logic [CNT_W-1:0] min_rec_i,
  input  logic [WIN_W-1:0] timeout_i,
  output logic             wake_o,
  output logic             rxd_o
);
  logic             sel_rec, cnt_inc, cnt_clr, hit;
  logic             win_start, win_run, win_clr, expired;
  logic [CNT_W-1:0] cur_min;

  assign cur_min = sel_rec ? min_rec_i : min_dom_i;

  bwd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .uv_i        (uv_i),
    .bus_dom_i   (bus_dom_i),
    .hit_i       (hit),
    .expired_i   (expired),
    .sel_rec_o   (sel_rec),
    .cnt_inc_o   (cnt_inc),
    .cnt_clr_o   (cnt_clr),
    .win_start_o (win_start),
    .win_run_o   (win_run),
    .win_clr_o   (win_clr),
    .wake_o      (wake_o),
    .rxd_o       (rxd_o)
  );

  bwd_phase_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .min_i  (cur_min),
    .hit_o  (hit)
  );

  bwd_win_timer #(.WIN_W(WIN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (win_clr),
    .start_i   (win_start),
    .run_i     (win_run),
    .limit_i   (timeout_i),
    .expired_o (expired)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_dom_i,
  input logic [1:0] mode_i,
  input logic       uv_i,
  input logic       wake_o,
  input logic       rxd_o
);
  p_reset_state_r1: assert property (@(posedge clk_i) !rst_ni |-> (!wake_o && rxd_o));

  p_wake_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_wake_last_dom_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(bus_dom_i));

  p_rxd_low_on_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !rxd_o);

  p_rxd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rxd_o && mode_i[1]) |=> !rxd_o);

  p_rxd_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rxd_o && !mode_i[1]) |=> rxd_o);

  p_wake_no_uv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> !$past(uv_i));

  p_wake_lp_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(mode_i[1]));

  p_wake_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(rxd_o));
endmodule

bind bus_wake_detector bwd_checker u_bwd_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_dom_i (bus_dom_i),
  .mode_i    (mode_i),
  .uv_i      (uv_i),
  .wake_o    (wake_o),
  .rxd_o     (rxd_o)
);

// File: tb/bus_wake_detector_tb_top.sv
module bus_wake_detector_tb_top;
  localparam int CNT_W = 16;
  localparam int WIN_W = 20;
  localparam logic [1:0] M_NORMAL = 2'b00, M_LISTEN = 2'b01, M_STBY = 2'b10, M_SLEEP = 2'b11;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_dom = 1'b0;
  logic [1:0]       mode = M_NORMAL;
  logic             uv = 1'b0;
  logic [CNT_W-1:0] min_dom = 16'd4;
  logic [CNT_W-1:0] min_rec = 16'd3;
  logic [WIN_W-1:0] timeout = 20'd30;
  logic             wake_o, rxd_o;

  int n_tests = 0;
  int n_fail  = 0;
  int wake_total = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_wake_detector #(.CNT_W(CNT_W), .WIN_W(WIN_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .bus_dom_i (bus_dom),
    .mode_i    (mode),
    .uv_i      (uv),
    .min_dom_i (min_dom),
    .min_rec_i (min_rec),
    .timeout_i (timeout),
    .wake_o    (wake_o),
    .rxd_o     (rxd_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one sample: drive, let the edge take it, look 1 ns later
  task automatic step(logic lvl);
    bus_dom = lvl;
    @(posedge clk);
    #1;
    if (wake_o) wake_total++;
  endtask

  task automatic send(logic lvl, int n);
    for (int i = 0; i < n; i++) step(lvl);
  endtask

  task automatic rearm(logic [1:0] m);
    mode = M_NORMAL;
    uv = 1'b0;
    step(1'b0);
    mode = m;
    step(1'b0);
    wake_total = 0;
  endtask

  task automatic t_reset;
    chk("R1", "wake_o in reset", int'(wake_o), 0);
    chk("R1", "rxd_o in reset", int'(rxd_o), 1);
    rst_ni = 1'b1;
    step(1'b0);
    chk("R1", "wake_o after reset", int'(wake_o), 0);
    chk("R1", "rxd_o after reset", int'(rxd_o), 1);
  endtask

  task automatic t_basic;
    min_dom = 4; min_rec = 3; timeout = 30;
    rearm(M_STBY);
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 3);
    chk("R2", "no wake before final sample", int'(wake_o), 0);
    chk("R5", "rxd high before wake", int'(rxd_o), 1);
    step(1'b1);
    chk("R2", "wake on final sample", int'(wake_o), 1);
    chk("R5", "rxd low with wake", int'(rxd_o), 0);
    step(1'b1);
    chk("R2", "wake lasts one cycle", int'(wake_o), 0);
    chk("R5", "rxd stays low in standby", int'(rxd_o), 0);
    send(1'b0, 3); send(1'b1, 5); send(1'b0, 3); send(1'b1, 5);
    chk("R9", "single wake until rearm", wake_total, 1);
    mode = M_NORMAL;
    step(1'b0);
    chk("R5", "rxd back high after leaving low power", int'(rxd_o), 1);
  endtask

  task automatic t_glitch;
    min_dom = 4; min_rec = 3; timeout = 30;
    rearm(M_STBY);
    send(1'b1, 2); send(1'b0, 1); send(1'b1, 2);
    send(1'b0, 2); send(1'b1, 1); send(1'b0, 1);
    send(1'b1, 1); send(1'b0, 2); send(1'b1, 2);
    chk("R3", "no wake one short of paused count", wake_total, 0);
    step(1'b1);
    chk("R3", "wake with paused phase counts", int'(wake_o), 1);
  endtask

  task automatic t_timeout;
    min_dom = 4; min_rec = 3;
    timeout = 11;
    rearm(M_SLEEP);
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 4);
    chk("R4", "pattern ending on last window cycle", wake_total, 1);
    timeout = 10;
    rearm(M_STBY);
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 4);
    chk("R4", "pattern one cycle too long", wake_total, 0);
    timeout = 12;
    rearm(M_STBY);
    send(1'b1, 4); send(1'b0, 3); send(1'b0, 6);
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 3);
    chk("R4", "no wake before retry completes", wake_total, 0);
    step(1'b1);
    chk("R4", "fresh pattern after expiry", int'(wake_o), 1);
  endtask

  task automatic t_normal_abort;
    min_dom = 4; min_rec = 3; timeout = 30;
    rearm(M_STBY);
    send(1'b1, 4); send(1'b0, 2);
    mode = M_NORMAL; step(1'b0);
    mode = M_STBY;
    send(1'b0, 1); send(1'b1, 4); send(1'b0, 2);
    chk("R6", "attempt dropped by normal mode", wake_total, 0);
    chk("R6", "rxd still high", int'(rxd_o), 1);
  endtask

  task automatic t_uv;
    min_dom = 4; min_rec = 3; timeout = 30;
    rearm(M_SLEEP);
    send(1'b1, 4); send(1'b0, 3);
    uv = 1'b1; step(1'b1);
    uv = 1'b0; send(1'b1, 3); send(1'b0, 2);
    chk("R7", "attempt dropped by undervoltage", wake_total, 0);
    rearm(M_SLEEP);
    uv = 1'b1;
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 4);
    chk("R7", "no start while undervoltage", wake_total, 0);
    uv = 1'b0;
  endtask

  task automatic t_inactive;
    min_dom = 4; min_rec = 3; timeout = 30;
    rearm(M_LISTEN);
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 4);
    chk("R8", "no wake in listen-only", wake_total, 0);
    mode = M_NORMAL;
    send(1'b1, 4); send(1'b0, 3); send(1'b1, 4);
    chk("R8", "no wake in normal", wake_total, 0);
    chk("R8", "rxd high outside low power", int'(rxd_o), 1);
  endtask

  initial begin
    #2;
    t_reset();
    t_basic();
    t_glitch();
    t_timeout();
    t_normal_abort();
    t_uv();
    t_inactive();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule